// File: doc/BRIEF.md
# VLIW Deferred Write Commit Queue

This block collects the register and program-counter updates produced by the instructions of one VLIW packet and holds them back until the packet ends. Every instruction in the packet therefore reads the state as it was before the packet began. When the commit is started, the queue replays its entries one per cycle in the order they arrived. Each entry carries the address of the instruction that queued it, a kind, a force flag, a destination index and a value.

Commit is selective. Only the first surviving program-counter update becomes the next PC. If an imprecise exception is pending, the writes of the faulting instruction are screened by exception class:
- For a floating-point exception, they survive only when the status holds nothing beyond the harmless conditions.
- For any other exception, only force-flagged writes survive.

When the link flag is set, the link register is loaded with the PC saved at the start of commit. After that the queue empties and a done pulse is given.

The surrounding pipeline uses the block as follows:
- Initialize the block at the start of a packet.
- Push entries as instructions execute.
- Optionally record a pending exception and the link request.
- Pulse the commit input, apply the data writes shown on the write port, and take the new PC from `pc_o` after the done pulse.

Top module: `vliw_commit_queue`

## Requirements
- R1: On a commit of N queued entries, the entries are presented strictly in push order from index 0, one per clock cycle, for exactly N cycles, followed by one done cycle.
- R2: While an entry is presented, `pc_o` equals the instruction address stored with that entry.
- R3: Among entries that pass filtering, only the first with kind 1 (direct PC write) or kind 2 (function-style PC write) sets the next PC; later PC writes in the same commit are dropped. A PC write's target is the low address-width bits of its value.
- R4: A pending exception filters only the entries whose instruction address equals the recorded exception address; all other entries commit normally.
- R5: For a floating-point exception, the faulting instruction's entries commit only if the recorded status has no bit set outside bits 0 to 2 (inexact, underflow, overflow).
- R6: For a non-floating-point exception, the faulting instruction's entries commit only if their force flag is set.
- R7: If the link flag was set before commit, `lr_we_o` pulses in the done cycle with `lr_val_o` equal to the PC saved at commit start, and the flag is cleared afterwards.
- R8: After the done cycle, `pc_o` holds the selected branch target, or the saved PC if no PC write was applied, and `count_o` is zero.
- R9: Initialization empties the queue, loads the packet PC from `init_pc_i`, and clears the pending exception and the link flag.
- R10: `full_o` is high when `count_o` equals DEPTH. A push while full is dropped, and `overflow_o` is high for the cycle after it.
- R11: Entries of kind 0 appear on the data write port; entries of kind 3 have no effect at all.
- R12: Push, init, exception and link inputs are ignored while a commit is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_i | input | 1 | Start a new packet |
| init_pc_i | input | AW | Packet start PC |
| push_i | input | 1 | Queue one entry |
| push_addr_i | input | AW | Issuing instruction address |
| push_kind_i | input | 2 | 0 data, 1 direct PC, 2 function PC, 3 none |
| push_force_i | input | 1 | Force-write flag |
| push_dst_i | input | RW | Destination register index |
| push_val_i | input | DW | Write value or PC target |
| exc_set_i | input | 1 | Record a pending imprecise exception |
| exc_addr_i | input | AW | Faulting instruction address |
| exc_fp_i | input | 1 | Exception is floating-point class |
| exc_status_i | input | SW | Floating-point exception status |
| link_set_i | input | 1 | Request link-register write at commit |
| commit_i | input | 1 | Start commit |
| full_o | output | 1 | Queue full |
| overflow_o | output | 1 | Push was dropped on a full queue |
| count_o | output | $clog2(DEPTH+1) | Entries queued |
| busy_o | output | 1 | Commit in progress |
| done_o | output | 1 | Commit finished pulse |
| pc_o | output | AW | Visible PC |
| wr_en_o | output | 1 | Data write strobe |
| wr_dst_o | output | RW | Data write destination |
| wr_val_o | output | DW | Data write value |
| lr_we_o | output | 1 | Link register write strobe |
| lr_val_o | output | AW | Link register value |

## Verification
The assertions are checked on every cycle. They cover these properties:
- The fill count never exceeds the depth, and a dropped push leaves the count unchanged.
- A done cycle always leaves an empty, idle queue.
- An accepted branch target stays fixed for the rest of the commit.
- The link strobe never lasts two cycles.
- A filtered entry never reaches the data write port.

The assertions do not show which entries commit, in what order, at which PC, or what the final PC is. Only the bench's scenarios show these, by sweeping fill levels, kind and force patterns, and each exception class against an arithmetic model.

// File: rtl/vcq_pkg.sv
// Package: shared encodings for the deferred write commit queue.
// Assumes: kind encoding is fixed and decoded by the pipeline that pushes.
package vcq_pkg;
    typedef enum logic [1:0] {
        K_DATA = 2'd0,
        K_PC   = 2'd1,
        K_FNPC = 2'd2,
        K_NONE = 2'd3
    } wkind_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } cstate_t;
endpackage

// File: rtl/vcq_store.sv
// Module: entry storage with fill count, full flag and overflow pulse.
// Assumes: DEPTH >= 2; clr_i has priority over a write in the same cycle.
module vcq_store #(
    parameter int DEPTH = 16,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int RW    = 5,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_i,
    input  logic           wr_i,
    input  logic [AW-1:0]  addr_i,
    input  vcq_pkg::wkind_t kind_i,
    input  logic           force_i,
    input  logic [RW-1:0]  dst_i,
    input  logic [DW-1:0]  val_i,
    input  logic [IW-1:0]  rd_idx_i,
    output logic [AW-1:0]  rd_addr_o,
    output vcq_pkg::wkind_t rd_kind_o,
    output logic           rd_force_o,
    output logic [RW-1:0]  rd_dst_o,
    output logic [DW-1:0]  rd_val_o,
    output logic [CW-1:0]  count_o,
    output logic           full_o,
    output logic           overflow_o
);
    logic [AW-1:0]   addr_q  [DEPTH];
    vcq_pkg::wkind_t kind_q  [DEPTH];
    logic            force_q [DEPTH];
    logic [RW-1:0]   dst_q   [DEPTH];
    logic [DW-1:0]   val_q   [DEPTH];
    logic [CW-1:0]   count_q;
    logic            ovf_q;

    assign full_o     = (count_q == CW'(DEPTH));
    assign count_o    = count_q;
    assign overflow_o = ovf_q;

    // Fill count and overflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            ovf_q <= wr_i && full_o && !clr_i;
            if (clr_i)
                count_q <= '0;
            else if (wr_i && !full_o)
                count_q <= count_q + CW'(1);
        end
    end

    // Entry payload, written at the current fill position.
    always_ff @(posedge clk) begin
        if (wr_i && !full_o && !clr_i) begin
            addr_q[count_q[IW-1:0]]  <= addr_i;
            kind_q[count_q[IW-1:0]]  <= kind_i;
            force_q[count_q[IW-1:0]] <= force_i;
            dst_q[count_q[IW-1:0]]   <= dst_i;
            val_q[count_q[IW-1:0]]   <= val_i;
        end
    end

    // Read port for the commit sequencer.
    always_comb begin
        rd_addr_o  = addr_q[rd_idx_i];
        rd_kind_o  = kind_q[rd_idx_i];
        rd_force_o = force_q[rd_idx_i];
        rd_dst_o   = dst_q[rd_idx_i];
        rd_val_o   = val_q[rd_idx_i];
    end

    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && full_o && !clr_i) |=> (overflow_o && count_o == $past(count_o)));
endmodule

// File: rtl/vcq_filter.sv
// Module: decides whether one entry survives a pending imprecise exception.
// Assumes: status bits in BENIGN are the harmless floating-point conditions.
module vcq_filter #(
    parameter int          AW     = 32,
    parameter int          SW     = 8,
    parameter logic [SW-1:0] BENIGN = SW'(7)
) (
    input  logic          pend_i,
    input  logic [AW-1:0] exc_addr_i,
    input  logic          fp_i,
    input  logic [SW-1:0] status_i,
    input  logic [AW-1:0] ent_addr_i,
    input  logic          force_i,
    output logic          pass_o
);
    logic hit;
    logic fp_ok;

    // Only the faulting instruction is screened; its class picks the rule.
    always_comb begin
        hit    = pend_i && (ent_addr_i == exc_addr_i);
        fp_ok  = ((status_i & ~BENIGN) == '0);
        pass_o = !hit || (fp_i ? fp_ok : force_i);
    end
endmodule

// File: rtl/vliw_commit_queue.sv
// Module: top of the deferred write commit queue. Holds a packet's writes
// and replays them one per cycle on commit, applying exception filtering,
// first-branch selection and the optional link write.
// Assumes: control inputs are honoured only while idle; DEPTH >= 2; AW <= DW.
module vliw_commit_queue #(
    parameter int            DEPTH  = 16,
    parameter int            AW     = 32,
    parameter int            DW     = 32,
    parameter int            RW     = 5,
    parameter int            SW     = 8,
    parameter logic [SW-1:0] BENIGN = SW'(7),
    localparam int           IW     = $clog2(DEPTH),
    localparam int           CW     = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_i,
    input  logic [AW-1:0] init_pc_i,
    input  logic          push_i,
    input  logic [AW-1:0] push_addr_i,
    input  logic [1:0]    push_kind_i,
    input  logic          push_force_i,
    input  logic [RW-1:0] push_dst_i,
    input  logic [DW-1:0] push_val_i,
    input  logic          exc_set_i,
    input  logic [AW-1:0] exc_addr_i,
    input  logic          exc_fp_i,
    input  logic [SW-1:0] exc_status_i,
    input  logic          link_set_i,
    input  logic          commit_i,
    output logic          full_o,
    output logic          overflow_o,
    output logic [CW-1:0] count_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [AW-1:0] pc_o,
    output logic          wr_en_o,
    output logic [RW-1:0] wr_dst_o,
    output logic [DW-1:0] wr_val_o,
    output logic          lr_we_o,
    output logic [AW-1:0] lr_val_o
);
    import vcq_pkg::*;

    cstate_t       state_q;
    logic [IW-1:0] idx_q;
    logic [AW-1:0] pc_q, saved_q, target_q;
    logic          taken_q, link_q;
    logic          xpend_q, xfp_q;
    logic [AW-1:0] xaddr_q;
    logic [SW-1:0] xstat_q;

    logic          idle, clr, accept, pass, apply, is_pc, last;
    logic [AW-1:0] rd_addr;
    wkind_t        rd_kind;
    logic          rd_force;
    logic [RW-1:0] rd_dst;
    logic [DW-1:0] rd_val;

    assign idle   = (state_q == S_IDLE);
    assign clr    = (idle && init_i) || (state_q == S_DONE);
    assign accept = idle && push_i && !init_i;

    vcq_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .RW(RW)) u_store (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .wr_i(accept),
        .addr_i(push_addr_i), .kind_i(wkind_t'(push_kind_i)),
        .force_i(push_force_i), .dst_i(push_dst_i), .val_i(push_val_i),
        .rd_idx_i(idx_q), .rd_addr_o(rd_addr), .rd_kind_o(rd_kind),
        .rd_force_o(rd_force), .rd_dst_o(rd_dst), .rd_val_o(rd_val),
        .count_o(count_o), .full_o(full_o), .overflow_o(overflow_o)
    );

    vcq_filter #(.AW(AW), .SW(SW), .BENIGN(BENIGN)) u_filter (
        .pend_i(xpend_q), .exc_addr_i(xaddr_q), .fp_i(xfp_q),
        .status_i(xstat_q), .ent_addr_i(rd_addr), .force_i(rd_force),
        .pass_o(pass)
    );

    // Per-entry decode of the presented entry.
    always_comb begin
        apply = (state_q == S_RUN) && pass;
        is_pc = (rd_kind == K_PC) || (rd_kind == K_FNPC);
        last  = ((CW'(idx_q) + CW'(1)) == count_o);
    end

    // Commit sequencer, packet PC, link flag and exception record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            idx_q    <= '0;
            pc_q     <= '0;
            saved_q  <= '0;
            target_q <= '0;
            taken_q  <= 1'b0;
            link_q   <= 1'b0;
            xpend_q  <= 1'b0;
            xfp_q    <= 1'b0;
            xaddr_q  <= '0;
            xstat_q  <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (init_i) begin
                        pc_q    <= init_pc_i;
                        link_q  <= 1'b0;
                        xpend_q <= 1'b0;
                        xfp_q   <= 1'b0;
                        xaddr_q <= '0;
                        xstat_q <= '0;
                    end else begin
                        if (exc_set_i) begin
                            xpend_q <= 1'b1;
                            xaddr_q <= exc_addr_i;
                            xfp_q   <= exc_fp_i;
                            xstat_q <= exc_status_i;
                        end
                        if (link_set_i)
                            link_q <= 1'b1;
                        if (commit_i) begin
                            saved_q  <= pc_q;
                            target_q <= pc_q;
                            taken_q  <= 1'b0;
                            idx_q    <= '0;
                            state_q  <= (count_o == '0) ? S_DONE : S_RUN;
                        end
                    end
                end
                S_RUN: begin
                    if (apply && is_pc && !taken_q) begin
                        taken_q  <= 1'b1;
                        target_q <= rd_val[AW-1:0];
                    end
                    if (last)
                        state_q <= S_DONE;
                    else
                        idx_q <= idx_q + IW'(1);
                end
                default: begin
                    pc_q    <= target_q;
                    link_q  <= 1'b0;
                    state_q <= S_IDLE;
                end
            endcase
        end
    end

    // Output drive: data write port, visible PC, link write, status.
    always_comb begin
        wr_en_o  = apply && (rd_kind == K_DATA);
        wr_dst_o = rd_dst;
        wr_val_o = rd_val;
        pc_o     = (state_q == S_RUN) ? rd_addr : pc_q;
        done_o   = (state_q == S_DONE);
        busy_o   = !idle;
        lr_we_o  = done_o && link_q;
        lr_val_o = saved_q;
    end

    p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (count_o == '0 && !busy_o));

    p_first_branch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && taken_q) |=> (taken_q && $stable(target_q)));

    p_link_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we_o |=> !lr_we_o);

    p_busy_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> $stable(count_o));

    p_force_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && xpend_q && !xfp_q && rd_addr == xaddr_q && !rd_force)
        |-> !wr_en_o);

    p_fp_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && xpend_q && xfp_q && rd_addr == xaddr_q
         && (xstat_q & ~BENIGN) != '0) |-> !wr_en_o);
endmodule

// File: tb/vliw_commit_queue_bench.sv
// Bench: sweeps fill level, kind/force patterns and exception classes on a
// four-entry queue and compares every commit with an arithmetic model.
module vliw_commit_queue_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int RW = 4;
    localparam int SW = 8;
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_i = 0, push_i = 0, push_force_i = 0, exc_set_i = 0;
    logic exc_fp_i = 0, link_set_i = 0, commit_i = 0;
    logic [AW-1:0] init_pc_i = '0, push_addr_i = '0, exc_addr_i = '0;
    logic [1:0]    push_kind_i = '0;
    logic [RW-1:0] push_dst_i = '0;
    logic [DW-1:0] push_val_i = '0;
    logic [SW-1:0] exc_status_i = '0;
    logic full_o, overflow_o, busy_o, done_o, wr_en_o, lr_we_o;
    logic [CW-1:0] count_o;
    logic [AW-1:0] pc_o, lr_val_o;
    logic [RW-1:0] wr_dst_o;
    logic [DW-1:0] wr_val_o;

    int ncmp = 0;
    int nfail = 0;

    vliw_commit_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .RW(RW), .SW(SW)) u_vliw_commit_queue (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .init_pc_i(init_pc_i),
        .push_i(push_i), .push_addr_i(push_addr_i), .push_kind_i(push_kind_i),
        .push_force_i(push_force_i), .push_dst_i(push_dst_i), .push_val_i(push_val_i),
        .exc_set_i(exc_set_i), .exc_addr_i(exc_addr_i), .exc_fp_i(exc_fp_i),
        .exc_status_i(exc_status_i), .link_set_i(link_set_i), .commit_i(commit_i),
        .full_o(full_o), .overflow_o(overflow_o), .count_o(count_o),
        .busy_o(busy_o), .done_o(done_o), .pc_o(pc_o), .wr_en_o(wr_en_o),
        .wr_dst_o(wr_dst_o), .wr_val_o(wr_val_o), .lr_we_o(lr_we_o),
        .lr_val_o(lr_val_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Monitor: logs data writes, run cycles and the done cycle.
    logic          mon_on = 0;
    int            nlog, runcyc;
    logic          seen_done, got_lrwe;
    logic [AW-1:0] got_lr;
    logic [RW-1:0] log_dst [8];
    logic [DW-1:0] log_val [8];
    logic [AW-1:0] log_pc  [8];

    always @(negedge clk) begin
        if (mon_on) begin
            if (wr_en_o && nlog < 8) begin
                log_dst[nlog] = wr_dst_o;
                log_val[nlog] = wr_val_o;
                log_pc[nlog]  = pc_o;
                nlog = nlog + 1;
            end
            if (busy_o && !done_o) runcyc = runcyc + 1;
            if (done_o) begin
                seen_done = 1;
                got_lrwe  = lr_we_o;
                got_lr    = lr_val_o;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        ncmp++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Entry payload generators.
    function automatic logic [AW-1:0] gen_addr(int i);
        return AW'(16'h0040 + 4 * (i / 2));
    endfunction
    function automatic logic [1:0] gen_kind(int p, int i);
        return 2'((p + i) % 4);
    endfunction
    function automatic logic gen_force(int p, int i);
        return 1'((p >> (i % 3)) & 1);
    endfunction
    function automatic logic [RW-1:0] gen_dst(int p, int i);
        return RW'(i + 1 + p);
    endfunction
    function automatic logic [DW-1:0] gen_val(int n, int p, int i);
        return DW'(16'h1000 + 16'h100 * p + 16'h10 * i + n);
    endfunction

    task automatic push_one(input logic [AW-1:0] a, input logic [1:0] k,
                            input logic f, input logic [RW-1:0] d, input logic [DW-1:0] v);
        push_i = 1; push_addr_i = a; push_kind_i = k; push_force_i = f;
        push_dst_i = d; push_val_i = v;
        @(negedge clk);
        push_i = 0;
    endtask

    task automatic start_packet(input logic [AW-1:0] pc);
        init_i = 1; init_pc_i = pc;
        @(negedge clk);
        init_i = 0;
    endtask

    // Commit and wait for the done cycle; extra_push pushes during run.
    task automatic do_commit(input bit extra_push);
        nlog = 0; runcyc = 0; seen_done = 0; got_lrwe = 0; got_lr = '0;
        mon_on = 1;
        commit_i = 1;
        @(negedge clk);
        commit_i = 0;
        if (extra_push) begin
            push_i = 1; push_addr_i = 16'h0f00; push_kind_i = 2'd0;
            push_dst_i = 4'hf; push_val_i = 16'hdead;
        end
        for (int g = 0; g < 30 && !seen_done; g++) @(negedge clk);
        push_i = 0;
        @(negedge clk);
        mon_on = 0;
    endtask

    // One sweep point: n entries, exception mode, pattern p.
    task automatic run_case(input int n, input int mode, input int p);
        logic [AW-1:0] xaddr, pc0, exp_pc;
        logic [SW-1:0] xstat;
        logic          xfp, taken, pass;
        int            en;
        logic [RW-1:0] e_dst [8];
        logic [DW-1:0] e_val [8];
        logic [AW-1:0] e_pc  [8];
        pc0 = AW'(16'h8000 + p);
        start_packet(pc0);
        for (int i = 0; i < n; i++)
            push_one(gen_addr(i), gen_kind(p, i), gen_force(p, i), gen_dst(p, i), gen_val(n, p, i));
        xaddr = gen_addr(2 * (p % 2));
        xfp   = (mode == 1 || mode == 2);
        xstat = (mode == 1) ? 8'h05 : (mode == 2) ? 8'h09 : 8'h02;
        exc_set_i = (mode != 0); exc_addr_i = xaddr; exc_fp_i = xfp;
        exc_status_i = xstat; link_set_i = p[0];
        @(negedge clk);
        exc_set_i = 0; link_set_i = 0;
        check(count_o == CW'(n), "R1 fill count", count_o, n);
        do_commit(0);
        // Model of the selective commit.
        en = 0; taken = 0; exp_pc = pc0;
        for (int i = 0; i < n; i++) begin
            pass = !(mode != 0 && gen_addr(i) == xaddr) ||
                   (xfp ? ((xstat & ~8'h07) == 0) : gen_force(p, i));
            if (pass && gen_kind(p, i) == 2'd0) begin
                e_dst[en] = gen_dst(p, i); e_val[en] = gen_val(n, p, i);
                e_pc[en] = gen_addr(i); en++;
            end
            if (pass && (gen_kind(p, i) == 2'd1 || gen_kind(p, i) == 2'd2) && !taken) begin
                taken = 1; exp_pc = gen_val(n, p, i);
            end
        end
        check(nlog == en, (mode == 0) ? "R11 write count" : (mode == 3) ? "R6 write count" :
              (mode == 2) ? "R5 write count" : "R4 write count", nlog, en);
        for (int i = 0; i < en && i < nlog; i++) begin
            check(log_dst[i] == e_dst[i] && log_val[i] == e_val[i], "R1 write order",
                  {log_dst[i], log_val[i]}, {e_dst[i], e_val[i]});
            check(log_pc[i] == e_pc[i], "R2 visible pc", log_pc[i], e_pc[i]);
        end
        check(runcyc == n, "R1 run cycles", runcyc, n);
        check(pc_o == exp_pc, "R3 R8 next pc", pc_o, exp_pc);
        check(count_o == 0, "R8 drained", count_o, 0);
        check(got_lrwe == p[0], "R7 link strobe", got_lrwe, p[0]);
        if (p[0]) check(got_lr == pc0, "R7 link value", got_lr, pc0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(count_o == 0 && !busy_o && !full_o && !done_o && pc_o == 0,
              "R9 reset state", {count_o, busy_o, full_o, done_o}, 0);

        for (int n = 0; n <= DEPTH; n++)
            for (int mode = 0; mode < 4; mode++)
                for (int p = 0; p < 8; p++)
                    run_case(n, mode, p);

        // R10: fill, then one push too many.
        start_packet(16'h9000);
        for (int i = 0; i < DEPTH; i++)
            push_one(AW'(16'h0200 + 4 * i), 2'd0, 0, RW'(i), DW'(16'h2000 + i));
        check(full_o == 1, "R10 full flag", full_o, 1);
        push_one(16'h0300, 2'd0, 0, 4'he, 16'hbeef);
        check(overflow_o == 1, "R10 overflow pulse", overflow_o, 1);
        check(count_o == CW'(DEPTH), "R10 dropped push", count_o, DEPTH);
        @(negedge clk);
        check(overflow_o == 0, "R10 overflow clears", overflow_o, 0);
        do_commit(0);
        check(nlog == DEPTH, "R10 commit count", nlog, DEPTH);
        check(log_val[DEPTH-1] == DW'(16'h2000 + DEPTH - 1), "R10 last entry kept",
              log_val[DEPTH-1], 16'h2000 + DEPTH - 1);

        // R12: a push during run is ignored.
        start_packet(16'h9100);
        push_one(16'h0400, 2'd0, 0, 4'h1, 16'h0011);
        push_one(16'h0404, 2'd0, 0, 4'h2, 16'h0022);
        do_commit(1);
        check(runcyc == 2, "R12 push while busy", runcyc, 2);
        check(nlog == 2, "R12 no extra write", nlog, 2);

        // R9: init clears the pending exception and link flag.
        start_packet(16'h9200);
        exc_set_i = 1; exc_addr_i = 16'h0500; exc_fp_i = 0; link_set_i = 1;
        @(negedge clk);
        exc_set_i = 0; link_set_i = 0;
        start_packet(16'h9300);
        check(count_o == 0 && pc_o == 16'h9300, "R9 init pc", pc_o, 16'h9300);
        push_one(16'h0500, 2'd0, 0, 4'h3, 16'h0033);
        do_commit(0);
        check(nlog == 1, "R9 exception cleared", nlog, 1);
        check(got_lrwe == 0, "R9 link cleared", got_lrwe, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        ncmp++;
        nfail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
        $finish;
    end
endmodule